// File: doc/BRIEF.md
# DRAM Request Decoder with Refresh-Row Register

This block sits behind the packet deserialiser of a DRAM command path. Each cycle it may receive one request word, already split into fields: a 4-bit opcode, a read/write select bit, bank, row, byte mask, a 3-bit refresh sub-opcode and an 8-bit refresh argument. It classifies the word and presents the resulting command, one cycle later, on a main command channel as a single-cycle strobe with a command code, bank, row and mask.

Refresh-class packets are handled separately. Two of their sub-opcodes load the low or the middle slice of an internal 12-bit refresh-row register. The refresh precharge and refresh activate sub-opcodes pick their bank from the low three argument bits and take a 0 to 3 cycle issue delay from the top two argument bits. They leave on a dedicated refresh channel once that delay has run. A refresh activate opens the row held in the register. The incrementing variant also advances the register by one after it issues. Only one delayed refresh may wait at a time. A refresh that arrives while one is waiting is dropped and reported.

Top module: `dram_req_decoder`

## Requirements
- R1: After a synchronous active-low reset, cmd_valid, cmd_illegal, ref_valid and ref_busy_err are 0 and refresh_row is 0.
- R2: A request sampled at a clock edge appears on the main channel right after that edge. cmd_valid is high for one cycle and cmd_code follows the opcode. 0000 gives NOP (0). 0001 gives RD (1) if req_wrx=0 and WR (2) if req_wrx=1. 0010 gives CAL (4). 01xx gives ACT (5). 1xxx gives WRM (3).
- R3: For ACT, cmd_bank and cmd_row carry req_bank and req_row. For WRM, cmd_mask carries req_mask, one bit per data byte.
- R4: With opcode 0011, the sub-opcode gives the following codes on the main channel. 000 gives RNOP (6). 100 gives LDLO (7). 101 gives LDMID (8). 110 gives LDHI (9). 111 raises cmd_illegal for one cycle, with no cmd_valid.
- R5: Sub-opcodes 001 (REFP, code 10), 010 (REFA, 11) and 011 (REFI, 12) produce no main-channel strobe. They produce a one-cycle ref_valid with that code and ref_bank = req_ra[2:0]. The strobe follows the accepting edge by d = 2*req_ra[7]+req_ra[6] further edges.
- R6: REFA and REFI report in ref_row the refresh-row value at the edge where they issue. REFP reports ref_row 0.
- R7: REFI adds one to refresh_row at its issue edge, and 4095 wraps to 0. REFA leaves the register unchanged.
- R8: LDLO writes req_ra[7:0] into row bits [7:0]. LDMID writes req_ra[3:0] into bits [11:8]. LDHI leaves refresh_row unchanged.
- R9: A REFP, REFA or REFI is dropped if it arrives at any edge after an accepted delayed refresh, up to and including that refresh's issue edge. A dropped request raises ref_busy_err for one cycle and never produces ref_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request word present this cycle |
| req_op | input | 4 | Opcode |
| req_wrx | input | 1 | Column packet: 0 read, 1 write |
| req_bank | input | 3 | Bank for column/activate |
| req_row | input | 12 | Row for activate |
| req_mask | input | 8 | Byte mask for masked write |
| req_sub | input | 3 | Refresh-packet sub-opcode |
| req_ra | input | 8 | Refresh argument: delay [7:6], bank [2:0], load data |
| cmd_valid | output | 1 | Main command strobe |
| cmd_code | output | 4 | Main command code |
| cmd_bank | output | 3 | Main command bank |
| cmd_row | output | 12 | Main command row |
| cmd_mask | output | 8 | Byte mask (WRM only, else 0) |
| cmd_illegal | output | 1 | Reserved encoding seen |
| ref_valid | output | 1 | Refresh command strobe |
| ref_code | output | 4 | Refresh command code |
| ref_bank | output | 3 | Refresh bank |
| ref_row | output | 12 | Refresh row |
| ref_busy_err | output | 1 | Refresh request dropped while one pends |
| refresh_row | output | 12 | Current refresh-row register |

## Verification
The hardest case to reach is a second refresh that lands exactly on the edge where the waiting one issues. At that edge the first strobe and the rejection of the second must both appear. The bench sends a refresh with delay 2, idles one cycle, then sends another. The 4095 wrap needs both register slices loaded to all ones before an incrementing refresh. The bench does this through the two load sub-opcodes.

// File: rtl/dram_dec_pkg.sv
// Shared command codes for the DRAM request decoder.
// Assumes: codes fit in 4 bits; values are visible on the output ports.
package dram_dec_pkg;
    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_RD    = 4'd1,
        CMD_WR    = 4'd2,
        CMD_WRM   = 4'd3,
        CMD_CAL   = 4'd4,
        CMD_ACT   = 4'd5,
        CMD_RNOP  = 4'd6,
        CMD_LDLO  = 4'd7,
        CMD_LDMID = 4'd8,
        CMD_LDHI  = 4'd9,
        CMD_REFP  = 4'd10,
        CMD_REFA  = 4'd11,
        CMD_REFI  = 4'd12
    } cmd_e;
endpackage

// File: rtl/op_classify.sv
// Combinational classifier: maps opcode, write select and refresh
// sub-opcode to a command code and side flags.
// Assumes: inputs are only meaningful when the request is valid.
module op_classify
    import dram_dec_pkg::*;
(
    input  logic [3:0] op_i,
    input  logic       wrx_i,
    input  logic [2:0] sub_i,
    output cmd_e       code_o,
    output logic       delayed_o,
    output logic       illegal_o,
    output logic       ld_lo_o,
    output logic       ld_mid_o
);
    // Decode the opcode, then the refresh sub-opcode for 0011.
    always_comb begin
        code_o    = CMD_NOP;
        delayed_o = 1'b0;
        illegal_o = 1'b0;
        ld_lo_o   = 1'b0;
        ld_mid_o  = 1'b0;
        if (op_i[3]) begin
            code_o = CMD_WRM;
        end else if (op_i[2]) begin
            code_o = CMD_ACT;
        end else begin
            case (op_i[1:0])
                2'b00: code_o = CMD_NOP;
                2'b01: code_o = wrx_i ? CMD_WR : CMD_RD;
                2'b10: code_o = CMD_CAL;
                default: begin
                    case (sub_i)
                        3'd0: code_o = CMD_RNOP;
                        3'd1: begin code_o = CMD_REFP; delayed_o = 1'b1; end
                        3'd2: begin code_o = CMD_REFA; delayed_o = 1'b1; end
                        3'd3: begin code_o = CMD_REFI; delayed_o = 1'b1; end
                        3'd4: begin code_o = CMD_LDLO; ld_lo_o = 1'b1; end
                        3'd5: begin code_o = CMD_LDMID; ld_mid_o = 1'b1; end
                        3'd6: code_o = CMD_LDHI;
                        default: illegal_o = 1'b1;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/refresh_row_reg.sv
// Split-loaded refresh-row register with wrapping increment.
// Assumes: a load in the same cycle as an increment takes priority.
module refresh_row_reg #(
    parameter int ROW_W = 12,
    parameter int LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo_i,
    input  logic             ld_mid_i,
    input  logic             inc_i,
    input  logic [LO_W-1:0]  data_i,
    output logic [ROW_W-1:0] row_o
);
    localparam int MID_W = ROW_W - LO_W;

    logic [ROW_W-1:0] row_q;

    // Load a slice, or advance the row after an incrementing refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (ld_lo_i) begin
            row_q[LO_W-1:0] <= data_i;
        end else if (ld_mid_i) begin
            row_q[ROW_W-1:LO_W] <= data_i[MID_W-1:0];
        end else if (inc_i) begin
            row_q <= row_q + 1'b1;
        end
    end

    assign row_o = row_q;

    // R7
    inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_lo_i && !ld_mid_i) |=> row_q == $past(row_q) + 1'b1);
    // R8
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo_i |=> row_q[LO_W-1:0] == $past(data_i));
endmodule

// File: rtl/refresh_delay.sv
// Holds at most one delayed refresh command and counts down its delay.
// Assumes: delay 0 issues at the accepting edge; issue_o is combinational
// and the parent registers it.
module refresh_delay
    import dram_dec_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int DLY_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  cmd_e              code_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [DLY_W-1:0]  dly_i,
    output logic              issue_o,
    output cmd_e              issue_code_o,
    output logic [BANK_W-1:0] issue_bank_o,
    output logic              err_o
);
    logic              pend_q;
    logic [DLY_W-1:0]  cnt_q;
    cmd_e              code_q;
    logic [BANK_W-1:0] bank_q;
    logic              accept;

    assign accept       = start_i && !pend_q;
    assign issue_o      = (accept && dly_i == '0) || (pend_q && cnt_q == '0);
    assign issue_code_o = pend_q ? code_q : code_i;
    assign issue_bank_o = pend_q ? bank_q : bank_i;

    // Capture a delayed command and count it down to issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            code_q <= CMD_NOP;
            bank_q <= '0;
        end else if (accept && dly_i != '0) begin
            pend_q <= 1'b1;
            cnt_q  <= dly_i - 1'b1;
            code_q <= code_i;
            bank_q <= bank_i;
        end else if (pend_q) begin
            if (cnt_q == '0) pend_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Flag a refresh that arrives while another is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= start_i && pend_q;
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> cnt_q < DLY_W'((1 << DLY_W) - 1));
    // R5
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && cnt_q != '0) |=> (pend_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dram_req_decoder.sv
// DRAM request decoder: classifies one request word per cycle onto a
// registered main command channel, and routes delayed refresh commands
// through a single-entry delay stage onto a refresh channel.
// Assumes: request fields are stable in the cycle req_valid is high.
module dram_req_decoder
    import dram_dec_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 3,
    parameter int MASK_W = 8,
    parameter int ARG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic              req_wrx,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [MASK_W-1:0] req_mask,
    input  logic [2:0]        req_sub,
    input  logic [ARG_W-1:0]  req_ra,
    output logic              cmd_valid,
    output logic [3:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [MASK_W-1:0] cmd_mask,
    output logic              cmd_illegal,
    output logic              ref_valid,
    output logic [3:0]        ref_code,
    output logic [BANK_W-1:0] ref_bank,
    output logic [ROW_W-1:0]  ref_row,
    output logic              ref_busy_err,
    output logic [ROW_W-1:0]  refresh_row
);
    localparam int DLY_W = 2;

    cmd_e              dec_code, iss_code;
    logic              dec_delayed, dec_illegal, dec_ld_lo, dec_ld_mid;
    logic              iss;
    logic [BANK_W-1:0] iss_bank;
    logic [ROW_W-1:0]  row_val;

    op_classify u_cls (
        .op_i(req_op), .wrx_i(req_wrx), .sub_i(req_sub),
        .code_o(dec_code), .delayed_o(dec_delayed), .illegal_o(dec_illegal),
        .ld_lo_o(dec_ld_lo), .ld_mid_o(dec_ld_mid)
    );

    refresh_delay #(.BANK_W(BANK_W), .DLY_W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n),
        .start_i(req_valid && dec_delayed), .code_i(dec_code),
        .bank_i(req_ra[BANK_W-1:0]), .dly_i(req_ra[ARG_W-1 -: DLY_W]),
        .issue_o(iss), .issue_code_o(iss_code), .issue_bank_o(iss_bank),
        .err_o(ref_busy_err)
    );

    refresh_row_reg #(.ROW_W(ROW_W), .LO_W(ARG_W)) u_row (
        .clk(clk), .rst_n(rst_n),
        .ld_lo_i(req_valid && dec_ld_lo), .ld_mid_i(req_valid && dec_ld_mid),
        .inc_i(iss && iss_code == CMD_REFI), .data_i(req_ra),
        .row_o(row_val)
    );

    assign refresh_row = row_val;

    // Register the main command channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid   <= 1'b0;
            cmd_illegal <= 1'b0;
            cmd_code    <= '0;
            cmd_bank    <= '0;
            cmd_row     <= '0;
            cmd_mask    <= '0;
        end else begin
            cmd_valid   <= req_valid && !dec_illegal && !dec_delayed;
            cmd_illegal <= req_valid && dec_illegal;
            cmd_code    <= dec_code;
            cmd_bank    <= req_bank;
            cmd_row     <= req_row;
            cmd_mask    <= (dec_code == CMD_WRM) ? req_mask : '0;
        end
    end

    // Register the refresh channel at the issue edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_valid <= 1'b0;
            ref_code  <= '0;
            ref_bank  <= '0;
            ref_row   <= '0;
        end else begin
            ref_valid <= iss;
            ref_code  <= iss_code;
            ref_bank  <= iss_bank;
            ref_row   <= (iss_code == CMD_REFP) ? '0 : row_val;
        end
    end

    // R2
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || cmd_illegal) |-> $past(req_valid));
    // R4
    illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, cmd_illegal}));
endmodule

// File: tb/sim_dram_req_decoder.sv
`timescale 1ns/1ps
module sim_dram_req_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic        req_wrx = 1'b0;
    logic [2:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0]  req_mask = '0;
    logic [2:0]  req_sub = '0;
    logic [7:0]  req_ra = '0;
    logic        cmd_valid, cmd_illegal, ref_valid, ref_busy_err;
    logic [3:0]  cmd_code, ref_code;
    logic [2:0]  cmd_bank, ref_bank;
    logic [11:0] cmd_row, ref_row, refresh_row;
    logic [7:0]  cmd_mask;

    int checks = 0;
    int errors = 0;
    int exp_row = 0;

    always #2.5 clk = ~clk;

    dram_req_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_wrx(req_wrx), .req_bank(req_bank), .req_row(req_row),
        .req_mask(req_mask), .req_sub(req_sub), .req_ra(req_ra),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_mask(cmd_mask), .cmd_illegal(cmd_illegal),
        .ref_valid(ref_valid), .ref_code(ref_code), .ref_bank(ref_bank),
        .ref_row(ref_row), .ref_busy_err(ref_busy_err), .refresh_row(refresh_row)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one request for one cycle; returns at the next falling edge.
    task automatic put(input int op, input int wrx, input int bank, input int row,
                       input int mask, input int sub, input int ra);
        req_valid = 1'b1; req_op = 4'(op); req_wrx = 1'(wrx);
        req_bank = 3'(bank); req_row = 12'(row); req_mask = 8'(mask);
        req_sub = 3'(sub); req_ra = 8'(ra);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic int main_code(input int op, input int wrx);
        if (op >= 8) return 3;
        if (op >= 4) return 5;
        if (op == 1) return wrx ? 2 : 1;
        if (op == 2) return 4;
        return 0;
    endfunction

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!cmd_valid && !cmd_illegal, "R1 strobes", int'(cmd_valid), 0);
        chk(!ref_valid && !ref_busy_err, "R1 ref", int'(ref_valid), 0);
        chk(refresh_row == 0, "R1 row", int'(refresh_row), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3: sweep every opcode except the refresh class
        for (int op = 0; op < 16; op++) begin
            for (int w = 0; w < 2; w++) begin
                if (op == 3) continue;
                put(op, w, op % 8, 100 * op + w, 8'h5A ^ op, 0, 0);
                chk(cmd_valid == 1'b1, "R2 valid", int'(cmd_valid), 1);
                chk(int'(cmd_code) == main_code(op, w), "R2 code",
                    int'(cmd_code), main_code(op, w));
                if (main_code(op, w) == 5) begin
                    chk(int'(cmd_bank) == op % 8, "R3 bank", int'(cmd_bank), op % 8);
                    chk(int'(cmd_row) == 100 * op + w, "R3 row", int'(cmd_row), 100 * op + w);
                end
                if (main_code(op, w) == 3)
                    chk(int'(cmd_mask) == (8'h5A ^ op), "R3 mask", int'(cmd_mask), 8'h5A ^ op);
                @(negedge clk);
                chk(!cmd_valid, "R2 one-cycle", int'(cmd_valid), 0);
            end
        end

        // R4 R8: immediate sub-opcodes and row loads
        put(3, 0, 0, 0, 0, 0, 8'hFF);
        chk(cmd_valid && cmd_code == 6, "R4 rnop", int'(cmd_code), 6);
        chk(refresh_row == 0, "R4 rnop row", int'(refresh_row), 0);
        put(3, 0, 0, 0, 0, 4, 8'hA5);
        exp_row = 12'h0A5;
        chk(cmd_valid && cmd_code == 7, "R4 ldlo", int'(cmd_code), 7);
        chk(refresh_row == exp_row, "R8 ldlo", int'(refresh_row), exp_row);
        put(3, 0, 0, 0, 0, 5, 8'hFC);
        exp_row = 12'hCA5;
        chk(cmd_valid && cmd_code == 8, "R4 ldmid", int'(cmd_code), 8);
        chk(refresh_row == exp_row, "R8 ldmid", int'(refresh_row), exp_row);
        put(3, 0, 0, 0, 0, 6, 8'h33);
        chk(cmd_valid && cmd_code == 9, "R4 ldhi", int'(cmd_code), 9);
        chk(refresh_row == exp_row, "R8 ldhi no effect", int'(refresh_row), exp_row);
        put(3, 0, 0, 0, 0, 7, 8'h00);
        chk(cmd_illegal && !cmd_valid, "R4 reserved", int'(cmd_illegal), 1);
        chk(!ref_valid, "R4 reserved no ref", int'(ref_valid), 0);
        @(negedge clk);

        // R5 R6 R7: every delayed sub-opcode at every delay
        for (int s = 1; s <= 3; s++) begin
            for (int d = 0; d < 4; d++) begin
                int bank = (s + d) % 8;
                put(3, 0, 0, 0, 0, s, (d << 6) | bank);
                chk(!cmd_valid, "R5 no main strobe", int'(cmd_valid), 0);
                for (int i = 0; i < 4; i++) begin
                    chk(ref_valid == (i == d), "R5 timing", int'(ref_valid), int'(i == d));
                    if (i == d) begin
                        chk(int'(ref_code) == 9 + s, "R5 code", int'(ref_code), 9 + s);
                        chk(int'(ref_bank) == bank, "R5 bank", int'(ref_bank), bank);
                        chk(int'(ref_row) == (s == 1 ? 0 : exp_row), "R6 row",
                            int'(ref_row), s == 1 ? 0 : exp_row);
                        if (s == 3) exp_row = (exp_row + 1) % 4096;
                        chk(int'(refresh_row) == exp_row, "R7 increment",
                            int'(refresh_row), exp_row);
                    end
                    if (i < 3) @(negedge clk);
                end
                @(negedge clk);
            end
        end

        // R7 wrap 4095 -> 0
        put(3, 0, 0, 0, 0, 4, 8'hFF);
        put(3, 0, 0, 0, 0, 5, 8'h0F);
        chk(refresh_row == 12'hFFF, "R8 full load", int'(refresh_row), 4095);
        put(3, 0, 0, 0, 0, 3, 8'h02);
        chk(ref_valid && ref_row == 12'hFFF, "R6 row at wrap", int'(ref_row), 4095);
        chk(refresh_row == 0, "R7 wrap", int'(refresh_row), 0);
        exp_row = 0;
        @(negedge clk);

        // R9 drop while pending
        put(3, 0, 0, 0, 0, 1, 8'hC1);            // REFP, delay 3
        put(3, 0, 0, 0, 0, 2, 8'h04);            // REFA, delay 0: dropped
        chk(ref_busy_err == 1'b1, "R9 err", int'(ref_busy_err), 1);
        chk(!ref_valid, "R9 dropped", int'(ref_valid), 0);
        @(negedge clk);
        chk(!ref_busy_err, "R9 err one-cycle", int'(ref_busy_err), 0);
        @(negedge clk);
        chk(ref_valid && ref_code == 10 && ref_bank == 1, "R9 first kept", int'(ref_code), 10);
        @(negedge clk);
        chk(!ref_valid, "R9 no late issue", int'(ref_valid), 0);

        // R9 collision on the issue edge itself
        put(3, 0, 0, 0, 0, 1, 8'h85);            // REFP, delay 2
        @(negedge clk);
        put(3, 0, 0, 0, 0, 2, 8'h06);            // arrives at issue edge
        chk(ref_valid && ref_bank == 5, "R9 issue edge strobe", int'(ref_bank), 5);
        chk(ref_busy_err == 1'b1, "R9 issue edge err", int'(ref_busy_err), 1);
        @(negedge clk);
        chk(!ref_valid, "R9 issue edge drop", int'(ref_valid), 0);
        put(3, 0, 0, 0, 0, 2, 8'h06);            // now accepted
        chk(ref_valid && ref_code == 11 && !ref_busy_err, "R9 accepted after",
            int'(ref_code), 11);
        chk(int'(ref_row) == exp_row, "R6 REFA row", int'(ref_row), exp_row);
        chk(int'(refresh_row) == exp_row, "R7 REFA no increment", int'(refresh_row), exp_row);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule